// File: doc/BRIEF.md
# ATA Command and PIO Data Sequencer

This block sits behind the task-file registers of one disk channel and handles the command register and the 16-bit data port for the drive that is currently selected. A command write is decoded against the drive's kind (packet device or hard disk). The block then updates the shared status and error registers, sets the interrupt-reason bits held in the sector-count register, and opens a programmed-I/O data phase when the command needs one. Every data phase runs through a 2048-byte transfer buffer, addressed by a byte index that counts up to a transfer length.

Three data phases exist. In packet entry the host writes a 12-byte command packet, which is then handed out on a one-cycle strobe. In identify readout the host reads buffer words that were preloaded through the fill port. In a packet read, which an outside packet interpreter starts with a total length and a per-request byte limit, the reads are split into increments of that limit. An interrupt is raised at each increment boundary. Whenever the buffer offset wraps to zero with data still to come, the block asks for a buffer refill and waits for an acknowledge before it accepts more reads.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset, status is 0x50, error is 0x01, interrupt reason is 0x01, and irq, pkt_valid and refill_req are low.
- R2: Command 0xA0 on a packet device clears busy (bit 7), write fault (bit 5) and error (bit 0) and sets data request (bit 3). It keeps the other status bits, sets interrupt reason to 0x01 and raises no interrupt.
- R3: Command 0xA0 on a drive that is not a packet device, command 0xEC on a drive that is not a hard disk, and any unrecognised code all abort. An abort gives status 0x41, error 0x04 and a one-cycle irq.
- R4: Command 0xA1, or 0xEC on a hard disk, sets status to 0x58 and error to 0x00, raises irq and opens a 512-byte identify readout.
- R5: Command 0xEF clears busy, write fault and error, sets ready (bit 6) and seek complete (bit 4), leaves error and data request unchanged, and raises irq.
- R6: In packet entry each data-port write stores one word at the index, low byte first. The write that reaches 12 bytes pulses pkt_valid with the packet (byte 0 in bits 7:0), clears data request and sets busy.
- R7: Identify reads return buffer words in order, and data request clears on the read that reaches 512 bytes (status becomes 0x50).
- R8: Starting a packet read gives status 0x58, interrupt reason 0x02 (I/O bit 1 set, command/data bit 0 clear), byte count equal to the total, and irq. At each increment boundary with data still remaining, the block keeps data request set, clears the command/data bit, writes the remaining byte count and raises irq.
- R9: The read that reaches the total length clears data request and busy and sets ready. It sets interrupt reason to 0x03 (command/data and I/O set, release bit 2 clear) and raises irq.
- R10: When a packet read leaves the buffer offset (index mod 2048) at zero with data remaining, refill_req rises with busy set and data request clear. Reads are ignored until refill_ack, which drops refill_req, clears busy and sets data request.
- R11: A data-port read with no data phase open is an overrun: the error bit of status is set and error becomes 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_code | input | 8 | Command code |
| dev_packet | input | 1 | Selected drive is a packet device |
| dev_disk | input | 1 | Selected drive is a hard disk |
| dwr_en | input | 1 | Data port write strobe |
| dwr_data | input | 16 | Data port write word |
| drd_en | input | 1 | Data port read strobe |
| drd_data | output | 16 | Data port read word, valid the cycle after drd_en |
| fill_we | input | 1 | Buffer fill write strobe |
| fill_addr | input | 10 | Buffer fill word address |
| fill_data | input | 16 | Buffer fill word |
| refill_req | output | 1 | Buffer refill wanted |
| refill_ack | input | 1 | Buffer refill done |
| xfer_start | input | 1 | Start a packet read phase |
| xfer_total | input | 16 | Total bytes of the packet read |
| xfer_limit | input | 16 | Bytes per host-requested increment |
| pkt_valid | output | 1 | One-cycle strobe: packet complete |
| pkt_bytes | output | 96 | Captured command packet |
| status | output | 8 | Status register |
| error | output | 8 | Error register |
| ireason | output | 8 | Sector count / interrupt reason register |
| byte_count | output | 16 | Byte count in the cylinder registers |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Within a single packet-read data-port read, an increment boundary and a buffer-offset wrap can fall together. The bench provokes this with a 2052-byte read whose per-request limit is 2048, so the 1024th read both completes the increment and empties the buffer. It then judges the result on the same cycle: the irq pulse and the 4-byte remaining count of the boundary, together with refill_req, busy set and data request clear from the wrap. A further read during the refill must change nothing, and after the acknowledge the wrapped reads must return the new buffer content.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  localparam int ST_ERR  = 0;
  localparam int ST_CORR = 2;
  localparam int ST_DRQ  = 3;
  localparam int ST_DSC  = 4;
  localparam int ST_DF   = 5;
  localparam int ST_DRDY = 6;
  localparam int ST_BSY  = 7;

  localparam int IR_CD  = 0;
  localparam int IR_IO  = 1;
  localparam int IR_REL = 2;

  localparam logic [7:0] CMD_PACKET   = 8'hA0;
  localparam logic [7:0] CMD_PKT_IDENT = 8'hA1;
  localparam logic [7:0] CMD_DISK_IDENT = 8'hEC;
  localparam logic [7:0] CMD_SET_FEAT = 8'hEF;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PKT_IN, PH_PKT_WAIT, PH_ID_OUT, PH_DATA_OUT, PH_REFILL
  } phase_t;

  typedef enum logic [2:0] {
    ACT_ABORT, ACT_PACKET, ACT_IDENT, ACT_FEATURE
  } act_t;
endpackage

// File: rtl/ata_cmd_decode.sv
module ata_cmd_decode
  import ata_seq_pkg::*;
(
  input  logic [7:0] cmd_code,
  input  logic       dev_packet,
  input  logic       dev_disk,
  output act_t       act
);
  always_comb begin
    unique case (cmd_code)
      CMD_PACKET:     act = dev_packet ? ACT_PACKET : ACT_ABORT;
      CMD_PKT_IDENT:  act = ACT_IDENT;
      CMD_DISK_IDENT: act = dev_disk ? ACT_IDENT : ACT_ABORT;
      CMD_SET_FEAT:   act = ACT_FEATURE;
      default:        act = ACT_ABORT;
    endcase
  end
endmodule

// File: rtl/ata_xfer_buf.sv
module ata_xfer_buf #(
  parameter int WORDS = 1024,
  parameter int DW    = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_seq_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int PKT_BYTES = 12,
  parameter int ID_BYTES  = 512,
  parameter int CW        = 16,
  localparam int BUF_WORDS = BUF_BYTES / 2,
  localparam int BAW       = $clog2(BUF_WORDS),
  localparam int BOFF      = $clog2(BUF_BYTES),
  localparam int PKT_WORDS = PKT_BYTES / 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_we,
  input  logic [7:0]             cmd_code,
  input  logic                   dev_packet,
  input  logic                   dev_disk,
  input  logic                   dwr_en,
  input  logic [15:0]            dwr_data,
  input  logic                   drd_en,
  output logic [15:0]            drd_data,
  input  logic                   fill_we,
  input  logic [BAW-1:0]         fill_addr,
  input  logic [15:0]            fill_data,
  output logic                   refill_req,
  input  logic                   refill_ack,
  input  logic                   xfer_start,
  input  logic [CW-1:0]          xfer_total,
  input  logic [CW-1:0]          xfer_limit,
  output logic                   pkt_valid,
  output logic [PKT_BYTES*8-1:0] pkt_bytes,
  output logic [7:0]             status,
  output logic [7:0]             error,
  output logic [7:0]             ireason,
  output logic [CW-1:0]          byte_count,
  output logic                   irq
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  act_t act;
  ata_cmd_decode u_dec (.cmd_code(cmd_code), .dev_packet(dev_packet),
                        .dev_disk(dev_disk), .act(act));

  phase_t        phase_q, phase_d;
  logic [7:0]    status_q, status_d, error_q, error_d, irs_q, irs_d;
  logic [CW-1:0] idx_q, idx_d, len_q, len_d, lim_q, lim_d, inc_q, inc_d;
  logic [CW-1:0] bcnt_q, bcnt_d, n_idx, n_inc;
  logic          irq_q, irq_d, pkv_q, pkv_d, rfl_q, rfl_d;
  logic [15:0]   pkt_q [PKT_WORDS];
  logic [15:0]   pkt_d [PKT_WORDS];
  logic          pkt_wr, buf_we, buf_re;
  logic [BAW-1:0] widx, buf_waddr;

  assign n_idx = idx_q + CW'(2);
  assign n_inc = inc_q + CW'(2);
  assign widx  = idx_q[BOFF-1:1];

  assign pkt_wr    = !cmd_we && !xfer_start && dwr_en && (phase_q == PH_PKT_IN);
  assign buf_we    = pkt_wr || fill_we;
  assign buf_waddr = pkt_wr ? widx : fill_addr;

  ata_xfer_buf #(.WORDS(BUF_WORDS), .DW(16)) u_buf (
    .clk(clk), .rst_n(rst_i_n), .we(buf_we), .waddr(buf_waddr),
    .wdata(pkt_wr ? dwr_data : fill_data), .re(buf_re), .raddr(widx),
    .rdata(drd_data));

  // next-state logic
  always_comb begin
    phase_d = phase_q; status_d = status_q; error_d = error_q; irs_d = irs_q;
    idx_d = idx_q; len_d = len_q; lim_d = lim_q; inc_d = inc_q;
    bcnt_d = bcnt_q; rfl_d = rfl_q; irq_d = 1'b0; pkv_d = 1'b0; buf_re = 1'b0;
    for (int w = 0; w < PKT_WORDS; w++) pkt_d[w] = pkt_q[w];

    if (cmd_we) begin
      rfl_d = 1'b0;
      unique case (act)
        ACT_ABORT: begin
          status_d = 8'h41; error_d = 8'h04; irq_d = 1'b1; phase_d = PH_IDLE;
        end
        ACT_PACKET: begin
          irs_d = 8'h01;
          status_d[ST_BSY] = 1'b0; status_d[ST_DF] = 1'b0;
          status_d[ST_ERR] = 1'b0; status_d[ST_DRQ] = 1'b1;
          len_d = CW'(PKT_BYTES); idx_d = '0; phase_d = PH_PKT_IN;
        end
        ACT_IDENT: begin
          status_d = 8'h58; error_d = 8'h00; irq_d = 1'b1;
          len_d = CW'(ID_BYTES); idx_d = '0; phase_d = PH_ID_OUT;
        end
        default: begin
          status_d[ST_BSY] = 1'b0; status_d[ST_DF] = 1'b0; status_d[ST_ERR] = 1'b0;
          status_d[ST_DRDY] = 1'b1; status_d[ST_DSC] = 1'b1; irq_d = 1'b1;
          if (phase_q == PH_REFILL) rfl_d = 1'b1;
        end
      endcase
    end else if (xfer_start) begin
      len_d = xfer_total; lim_d = xfer_limit; idx_d = '0; inc_d = '0;
      status_d = 8'h58; irs_d = 8'h02; bcnt_d = xfer_total; irq_d = 1'b1;
      rfl_d = 1'b0; phase_d = PH_DATA_OUT;
    end else if (refill_ack && phase_q == PH_REFILL) begin
      rfl_d = 1'b0; status_d[ST_BSY] = 1'b0; status_d[ST_DRQ] = 1'b1;
      phase_d = PH_DATA_OUT;
    end else if (pkt_wr) begin
      for (int w = 0; w < PKT_WORDS; w++)
        if (widx == BAW'(w)) pkt_d[w] = dwr_data;
      idx_d = n_idx;
      if (n_idx >= len_q) begin
        pkv_d = 1'b1; status_d[ST_DRQ] = 1'b0; status_d[ST_BSY] = 1'b1;
        phase_d = PH_PKT_WAIT;
      end
    end else if (drd_en) begin
      if (phase_q == PH_ID_OUT) begin
        buf_re = 1'b1; idx_d = n_idx;
        status_d[ST_DRDY] = 1'b1; status_d[ST_DSC] = 1'b1; status_d[ST_BSY] = 1'b0;
        status_d[ST_DF] = 1'b0; status_d[ST_CORR] = 1'b0; status_d[ST_ERR] = 1'b0;
        if (n_idx >= len_q) begin
          status_d[ST_DRQ] = 1'b0; phase_d = PH_IDLE;
        end
      end else if (phase_q == PH_DATA_OUT) begin
        buf_re = 1'b1; idx_d = n_idx; inc_d = n_inc;
        if (n_idx >= len_q) begin
          status_d[ST_DRQ] = 1'b0; status_d[ST_DRDY] = 1'b1; status_d[ST_BSY] = 1'b0;
          irs_d[IR_CD] = 1'b1; irs_d[IR_REL] = 1'b0; irs_d[IR_IO] = 1'b1;
          irq_d = 1'b1; phase_d = PH_IDLE;
        end else begin
          if (n_inc >= lim_q) begin
            inc_d = '0; status_d[ST_DRQ] = 1'b1; irs_d[IR_CD] = 1'b0;
            bcnt_d = len_q - n_idx; irq_d = 1'b1;
          end
          if (n_idx[BOFF-1:0] == '0) begin
            rfl_d = 1'b1; status_d[ST_BSY] = 1'b1; status_d[ST_DRQ] = 1'b0;
            phase_d = PH_REFILL;
          end
        end
      end else if (phase_q == PH_IDLE) begin
        status_d[ST_ERR] = 1'b1; error_d = 8'h04;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      phase_q <= PH_IDLE; status_q <= 8'h50; error_q <= 8'h01; irs_q <= 8'h01;
      idx_q <= '0; len_q <= '0; lim_q <= '0; inc_q <= '0; bcnt_q <= '0;
      irq_q <= 1'b0; pkv_q <= 1'b0; rfl_q <= 1'b0;
      for (int w = 0; w < PKT_WORDS; w++) pkt_q[w] <= '0;
    end else begin
      phase_q <= phase_d; status_q <= status_d; error_q <= error_d; irs_q <= irs_d;
      idx_q <= idx_d; len_q <= len_d; lim_q <= lim_d; inc_q <= inc_d;
      bcnt_q <= bcnt_d; irq_q <= irq_d; pkv_q <= pkv_d; rfl_q <= rfl_d;
      for (int w = 0; w < PKT_WORDS; w++) pkt_q[w] <= pkt_d[w];
    end
  end

  for (genvar g = 0; g < PKT_WORDS; g++) begin : g_pkt
    assign pkt_bytes[g*16 +: 16] = pkt_q[g];
  end

  assign status = status_q;
  assign error = error_q;
  assign ireason = irs_q;
  assign byte_count = bcnt_q;
  assign irq = irq_q;
  assign pkt_valid = pkv_q;
  assign refill_req = rfl_q;

  // assertions
  assert_abort_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_we && act == ACT_ABORT) |=> (status_q == 8'h41 && error_q == 8'h04 && irq_q));
  assert_ident_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_we && act == ACT_IDENT) |=> (status_q == 8'h58 && error_q == 8'h00 && irq_q));
  assert_pkt_done_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    pkv_q |-> (status_q[ST_BSY] && !status_q[ST_DRQ]));
  assert_final_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!cmd_we && !xfer_start && drd_en && phase_q == PH_DATA_OUT && n_idx >= len_q)
    |=> (irs_q[1:0] == 2'b11 && !status_q[ST_DRQ] && irq_q));
  assert_refill_busy_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    rfl_q |-> (status_q[ST_BSY] && !status_q[ST_DRQ]));
  assert_refill_hold_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rfl_q && !refill_ack && !cmd_we && !xfer_start) |=> ($stable(idx_q) && rfl_q));
endmodule

// File: tb/ata_pio_seq_test.sv
module ata_pio_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 0, dev_packet = 0, dev_disk = 0, dwr_en = 0, drd_en = 0;
  logic fill_we = 0, refill_ack = 0, xfer_start = 0;
  logic [7:0] cmd_code = 0;
  logic [15:0] dwr_data = 0, fill_data = 0, xfer_total = 0, xfer_limit = 0;
  logic [9:0] fill_addr = 0;
  logic [15:0] drd_data, byte_count;
  logic refill_req, pkt_valid, irq;
  logic [95:0] pkt_bytes;
  logic [7:0] status, error, ireason;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  ata_pio_seq uut (.*);

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] c, input logic pk, input logic dk);
    cmd_code = c; dev_packet = pk; dev_disk = dk; cmd_we = 1;
    @(negedge clk); cmd_we = 0;
  endtask
  task automatic do_write(input logic [15:0] d);
    dwr_data = d; dwr_en = 1; @(negedge clk); dwr_en = 0;
  endtask
  task automatic do_read();
    drd_en = 1; @(negedge clk); drd_en = 0;
  endtask
  task automatic do_fill(input int a, input logic [15:0] d);
    fill_addr = 10'(a); fill_data = d; fill_we = 1; @(negedge clk); fill_we = 0;
  endtask
  task automatic do_start(input logic [15:0] t, input logic [15:0] l);
    xfer_total = t; xfer_limit = l; xfer_start = 1; @(negedge clk); xfer_start = 0;
  endtask
  task automatic do_ack();
    refill_ack = 1; @(negedge clk); refill_ack = 0;
  endtask

  // {cmd, packet, disk, status, error, irq}
  localparam logic [26:0] VEC [8] = '{
    {8'hEF, 1'b0, 1'b1, 8'h50, 8'h01, 1'b1},
    {8'hA0, 1'b0, 1'b1, 8'h41, 8'h04, 1'b1},
    {8'hEF, 1'b0, 1'b1, 8'h50, 8'h04, 1'b1},
    {8'hA0, 1'b1, 1'b0, 8'h58, 8'h04, 1'b0},
    {8'hEC, 1'b1, 1'b0, 8'h41, 8'h04, 1'b1},
    {8'h20, 1'b0, 1'b1, 8'h41, 8'h04, 1'b1},
    {8'hA1, 1'b1, 1'b0, 8'h58, 8'h00, 1'b1},
    {8'hEC, 1'b0, 1'b1, 8'h58, 8'h00, 1'b1}
  };
  localparam string VREQ [8] = '{"R5", "R3", "R5", "R2", "R3", "R3", "R4", "R4"};

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mism;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", 96'(status), 96'h50);
    check("R1 error", 96'(error), 96'h01);
    check("R1 ireason", 96'(ireason), 96'h01);
    check("R1 pulses", 96'({irq, pkt_valid, refill_req}), 96'h0);

    for (int i = 0; i < 8; i++) begin
      do_cmd(VEC[i][26:19], VEC[i][18], VEC[i][17]);
      check({VREQ[i], " status"}, 96'(status), 96'(VEC[i][16:9]));
      check({VREQ[i], " error"}, 96'(error), 96'(VEC[i][8:1]));
      check({VREQ[i], " irq"}, 96'(irq), 96'(VEC[i][0]));
      if (VEC[i][26:19] == 8'hA0 && VEC[i][18])
        check("R2 ireason", 96'(ireason), 96'h01);
    end

    // R7 identify readout
    for (int a = 0; a < 256; a++) do_fill(a, 16'hC000 ^ 16'(a * 3));
    do_cmd(8'hA1, 1'b1, 1'b0);
    mism = 0;
    for (int i = 0; i < 256; i++) begin
      if (i == 255) check("R7 drq before last", 96'(status[3]), 96'h1);
      do_read();
      if (drd_data !== (16'hC000 ^ 16'(i * 3))) mism++;
    end
    check("R7 data words", 96'(mism), 96'h0);
    check("R7 status after", 96'(status), 96'h50);

    // R6 packet entry
    do_cmd(8'hA0, 1'b1, 1'b0);
    check("R2 status", 96'(status), 96'h58);
    for (int i = 0; i < 6; i++) begin
      do_write(16'h1100 + 16'(i));
      if (i == 4) check("R6 no early strobe", 96'(pkt_valid), 96'h0);
    end
    check("R6 strobe", 96'(pkt_valid), 96'h1);
    check("R6 packet", pkt_bytes,
          {16'h1105, 16'h1104, 16'h1103, 16'h1102, 16'h1101, 16'h1100});
    check("R6 status", 96'(status), 96'hD0);
    @(negedge clk);
    check("R6 strobe one cycle", 96'(pkt_valid), 96'h0);

    // R8/R9 increments
    for (int a = 0; a < 6; a++) do_fill(a, 16'h7700 + 16'(a));
    do_start(16'd12, 16'd4);
    check("R8 start status", 96'(status), 96'h58);
    check("R8 start ireason", 96'(ireason), 96'h02);
    check("R8 start count", 96'(byte_count), 96'd12);
    check("R8 start irq", 96'(irq), 96'h1);
    for (int i = 0; i < 6; i++) begin
      do_read();
      check("R8 data", 96'(drd_data), 96'(16'h7700 + 16'(i)));
      if (i == 0) check("R8 mid increment no irq", 96'(irq), 96'h0);
      if (i == 1) begin
        check("R8 boundary count", 96'(byte_count), 96'd8);
        check("R8 boundary irq", 96'(irq), 96'h1);
        check("R8 boundary ireason", 96'(ireason), 96'h02);
        check("R8 boundary status", 96'(status), 96'h58);
      end
      if (i == 3) check("R8 second boundary", 96'(byte_count), 96'd4);
    end
    check("R9 status", 96'(status), 96'h50);
    check("R9 ireason", 96'(ireason), 96'h03);
    check("R9 irq", 96'(irq), 96'h1);

    // R11 overrun
    do_read();
    check("R11 status", 96'(status), 96'h51);
    check("R11 error", 96'(error), 96'h04);

    // R10 refill coinciding with an increment boundary
    for (int a = 0; a < 1024; a++) do_fill(a, 16'h5A00 ^ 16'(a));
    do_start(16'd2052, 16'd2048);
    mism = 0;
    for (int i = 0; i < 1024; i++) begin
      do_read();
      if (drd_data !== (16'h5A00 ^ 16'(i))) mism++;
    end
    check("R10 data before wrap", 96'(mism), 96'h0);
    check("R10 refill_req", 96'(refill_req), 96'h1);
    check("R10 status", 96'(status), 96'hD0);
    check("R8 count at wrap", 96'(byte_count), 96'd4);
    check("R8 irq at wrap", 96'(irq), 96'h1);
    check("R8 ireason at wrap", 96'(ireason), 96'h02);
    do_read();
    check("R10 ignored read count", 96'(byte_count), 96'd4);
    check("R10 ignored read status", 96'(status), 96'hD0);
    check("R10 ignored read irq", 96'(irq), 96'h0);
    check("R10 still waiting", 96'(refill_req), 96'h1);
    do_fill(0, 16'hBEEF);
    do_fill(1, 16'hCAFE);
    do_ack();
    check("R10 ack clears req", 96'(refill_req), 96'h0);
    check("R10 ack status", 96'(status), 96'h58);
    do_read();
    check("R10 refilled word 0", 96'(drd_data), 96'hBEEF);
    do_read();
    check("R10 refilled word 1", 96'(drd_data), 96'hCAFE);
    check("R9 final after wrap", 96'(ireason), 96'h03);
    check("R9 final status", 96'(status), 96'h50);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule